// File: doc/BRIEF.md
# Trigger-Sensed Byte-Lane Static Memory

A clocked, synthesizable model of a 32-bit static memory made of four independent byte-wide banks. All banks see one shared word address and one shared active-low output enable. Each bank has its own active-low select and active-low write strobe. Any combination of banks can take part in a single access, so the surrounding logic can perform 8-, 16-, 24- or 32-bit transfers.

The read side saves power by sensing only on demand. A bank copies a byte from its array into its output register only after a read trigger. A trigger is a falling edge of the bank's select, or any change of the address while the bank is selected. Between triggers the register keeps presenting its last sensed byte, even after a write has changed that location.

Triggers that arrive while the first few cycles of a sense are still open merge into that sense. A trigger that arrives after the window has closed, but before the sense completes, abandons the sense, starts a new one and raises a per-bank restart flag. Three-state behaviour is modelled as a per-lane drive-enable output, and an undriven lane reads as zero.

Top module: `trigsram_array`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every sensed byte to 0 and clears sense_restart. The first cycle after reset therefore shows 0 on any driven lane.
- R2: Byte lane b occupies rdata and wdata bits [8b+7:8b]. At a clock edge where sel_n[b]=0 and wr_n[b]=0, bank b stores wdata lane b at addr. The value of oe_n has no effect on the write.
- R3: A bank with sel_n[b]=1 is in standby: drive_en[b]=0, rdata lane b reads 0, and the bank stores nothing whatever wr_n[b] and wdata are. Other banks are unaffected.
- R4: While a bank writes (sel_n[b]=0 and wr_n[b]=0), drive_en[b]=0 and its lane reads 0, regardless of oe_n.
- R5: drive_en[b]=1 exactly when sel_n[b]=0, wr_n[b]=1 and oe_n=0. A driven lane shows the bank's sensed byte. Toggling oe_n alone starts no sense and reveals the byte already held.
- R6: A read trigger is a 1-to-0 change of sel_n[b], or any change of addr while sel_n[b]=0. If the trigger is taken at edge k, the array byte appears on the lane after edge k+SENSE_LEN. Until then the previous sensed byte stays on the lane.
- R7: Without a trigger, the lane keeps its previously sensed byte, even if that array location is rewritten.
- R8: A trigger taken while a sense is 1..SENSE_WIN cycles old merges into that sense. No restart flag is raised, the sense still completes at edge k+SENSE_LEN, and it reads the newest address.
- R9: A trigger taken later than that, but no later than the completing edge, restarts the sense. sense_restart[b] is 1 for the one cycle after that edge, and the byte for the new address appears SENSE_LEN edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address shared by all banks |
| oe_n | input | 1 | Shared active-low output enable |
| sel_n | input | 4 | Active-low select, one per bank |
| wr_n | input | 4 | Active-low write strobe, one per bank |
| wdata | input | 32 | Write data, byte lane b for bank b |
| rdata | output | 32 | Read data; a lane not driven reads 0 |
| drive_en | output | 4 | Per-lane drive enable (1 = lane driven) |
| sense_restart | output | 4 | One-cycle flag: a late trigger restarted the bank's sense |

## Verification
A corrupted trigger history or sense counter shows up at rdata as a byte that arrives one or more edges early or late against the k+SENSE_LEN rule, or as a stale byte that changes without a trigger. Such errors are visible within SENSE_LEN+1 cycles of the trigger. A wrong merge/restart decision appears in sense_restart on the very next cycle and shifts the data arrival by the restart distance. Array or lane-mapping errors appear as a wrong byte on the first sensed read of the affected address, which the full-address sweep with arithmetic patterns reaches for every bank.

// File: rtl/trigsram_pkg.sv
// Shared definitions for the trigger-sensed byte-lane memory.
// Assumes four byte lanes; the bank mode decode is the single source
// for how select, write strobe and output enable combine.
package trigsram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        BANK_STANDBY    = 2'd0,
        BANK_WRITE      = 2'd1,
        BANK_READ_QUIET = 2'd2,
        BANK_READ_DRIVE = 2'd3
    } bank_mode_e;

    // Decode one bank's pins into its operating mode (select has priority).
    function automatic bank_mode_e bank_mode(input logic sel_n,
                                             input logic wr_n,
                                             input logic oe_n);
        if (sel_n)
            return BANK_STANDBY;
        else if (!wr_n)
            return BANK_WRITE;
        else if (oe_n)
            return BANK_READ_QUIET;
        else
            return BANK_READ_DRIVE;
    endfunction

endpackage

// File: rtl/trigsram_trigger.sv
// Read-trigger detector and sense sequencer for one bank.
// Detects select falls and address changes while selected, merges
// triggers inside the first SENSE_WIN cycles of a sense, restarts on
// later triggers and pulses sense_fire on the completing edge.
// Assumes SENSE_LEN > SENSE_WIN >= 0 and SENSE_LEN >= 1.
module trigsram_trigger #(
    parameter int ADDR_W    = 8,
    parameter int SENSE_WIN = 1,
    parameter int SENSE_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              sense_fire,
    output logic [ADDR_W-1:0] sense_addr,
    output logic              restart
);

    localparam int CNT_W = $clog2(SENSE_LEN + 1);
    localparam logic [CNT_W-1:0] WIN_C  = CNT_W'(SENSE_WIN);
    localparam logic [CNT_W-1:0] LEN_C  = CNT_W'(SENSE_LEN);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO_C = '0;

    logic              prev_sel_n_r;
    logic [ADDR_W-1:0] prev_addr_r;
    logic [CNT_W-1:0]  cnt_r;
    logic              restart_r;
    logic [ADDR_W-1:0] sense_addr_r;

    logic sel_fall;
    logic addr_move;
    logic trig;
    logic busy;
    logic in_win;

    // Classify this cycle's inputs against the previous cycle's.
    always_comb begin
        sel_fall  = prev_sel_n_r && !sel_n;
        addr_move = !sel_n && (addr != prev_addr_r);
        trig      = sel_fall || addr_move;
        busy      = (cnt_r != ZERO_C);
        in_win    = busy && (cnt_r <= WIN_C);
    end

    // Remember last cycle's select and address for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sel_n_r <= 1'b1;
            prev_addr_r  <= '0;
        end else begin
            prev_sel_n_r <= sel_n;
            prev_addr_r  <= addr;
        end
    end

    // Sense age counter: start, merge, restart, complete or cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_r     <= ZERO_C;
            restart_r <= 1'b0;
        end else begin
            restart_r <= 1'b0;
            if (sel_n) begin
                cnt_r <= ZERO_C;
            end else if (trig && !busy) begin
                cnt_r <= ONE_C;
            end else if (trig && !in_win) begin
                cnt_r     <= ONE_C;
                restart_r <= 1'b1;
            end else if (busy) begin
                cnt_r <= (cnt_r == LEN_C) ? ZERO_C : cnt_r + ONE_C;
            end
        end
    end

    // Latch the newest triggering address for the sense to read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sense_addr_r <= '0;
        else if (trig)
            sense_addr_r <= addr;
    end

    assign sense_fire = (cnt_r == LEN_C) && !sel_n && !trig;
    assign sense_addr = sense_addr_r;
    assign restart    = restart_r;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt_r == ZERO_C && !restart_r && sense_addr_r == '0));

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_r <= LEN_C);

    assert_deselect_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (cnt_r == ZERO_C));

    assert_merge_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && in_win && !sel_n) |=> !restart_r);

    assert_restart_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_r |-> (cnt_r == ONE_C));

endmodule

// File: rtl/trigsram_bank.sv
// One byte-wide bank: storage array, trigger-sensed output register
// and lane drive control. The array itself is not reset; only the
// sensed register and the sequencer clear on rst_n.
// A capture and a write to the same location on one edge return the
// byte held before the write.
module trigsram_bank
    import trigsram_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SENSE_WIN = 1,
    parameter int SENSE_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wbyte,
    output logic [LANE_W-1:0] lane_out,
    output logic              drive,
    output logic              restart
);

    localparam int DEPTH = 1 << ADDR_W;

    bank_mode_e        mode;
    logic              sense_fire;
    logic [ADDR_W-1:0] sense_addr;
    logic [LANE_W-1:0] q_r;
    logic [LANE_W-1:0] mem [DEPTH];

    // Decode this bank's operating mode from its pins.
    assign mode = bank_mode(sel_n, wr_n, oe_n);

    trigsram_trigger #(
        .ADDR_W   (ADDR_W),
        .SENSE_WIN(SENSE_WIN),
        .SENSE_LEN(SENSE_LEN)
    ) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .addr      (addr),
        .sense_fire(sense_fire),
        .sense_addr(sense_addr),
        .restart   (restart)
    );

    // Store the lane byte on a selected write edge.
    always_ff @(posedge clk) begin
        if (rst_n && mode == BANK_WRITE)
            mem[addr] <= wbyte;
    end

    // Capture the array byte only when a sense completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_r <= '0;
        else if (sense_fire)
            q_r <= mem[sense_addr];
    end

    assign drive    = (mode == BANK_READ_DRIVE);
    assign lane_out = drive ? q_r : '0;

    assert_stale_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_fire |=> $stable(q_r));

    assert_fire_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sense_fire |-> (mode != BANK_STANDBY));

endmodule

// File: rtl/trigsram_array.sv
// Four-bank, 32-bit trigger-sensed memory. Banks share address and
// output enable; each has its own select and write strobe. Lane b of
// the data buses belongs to bank b.
// Assumes SENSE_LEN > SENSE_WIN; an undriven lane is presented as 0.
module trigsram_array
    import trigsram_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SENSE_WIN = 1,
    parameter int SENSE_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic [LANES-1:0]  sel_n,
    input  logic [LANES-1:0]  wr_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  drive_en,
    output logic [LANES-1:0]  sense_restart
);

    // One bank per byte lane.
    for (genvar b = 0; b < LANES; b++) begin : g_bank
        trigsram_bank #(
            .ADDR_W   (ADDR_W),
            .SENSE_WIN(SENSE_WIN),
            .SENSE_LEN(SENSE_LEN)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_n   (sel_n[b]),
            .wr_n    (wr_n[b]),
            .oe_n    (oe_n),
            .addr    (addr),
            .wbyte   (wdata[b*LANE_W +: LANE_W]),
            .lane_out(rdata[b*LANE_W +: LANE_W]),
            .drive   (drive_en[b]),
            .restart (sense_restart[b])
        );

        assert_write_undriven_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_n[b] && !wr_n[b]) |-> !drive_en[b]);

        assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            sel_n[b] |-> (!drive_en[b] && rdata[b*LANE_W +: LANE_W] == '0));
    end

endmodule

// File: tb/trigsram_array_test.sv
module trigsram_array_test;

    localparam int AW  = 8;
    localparam int WIN = 1;
    localparam int LEN = 3;
    localparam int NA  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          oe_n;
    logic [3:0]    sel_n;
    logic [3:0]    wr_n;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [3:0]    drive_en;
    logic [3:0]    sense_restart;

    int errs   = 0;
    int checks = 0;

    always #10 clk = ~clk;

    trigsram_array #(.ADDR_W(AW), .SENSE_WIN(WIN), .SENSE_LEN(LEN)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .oe_n(oe_n),
        .sel_n(sel_n), .wr_n(wr_n), .wdata(wdata),
        .rdata(rdata), .drive_en(drive_en), .sense_restart(sense_restart)
    );

    function automatic logic [7:0] pat(int b, int a);
        return 8'((a * 37 + b * 91 + 5) & 255);
    endfunction

    function automatic logic [31:0] word(int a);
        return {pat(3, a), pat(2, a), pat(1, a), pat(0, a)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic idle();
        sel_n = 4'hF;
        wr_n  = 4'hF;
        oe_n  = 1'b1;
    endtask

    // Trigger a read at a; check latency boundary (R6) and result.
    task automatic read_at(int a, logic [31:0] prev, bit chk_prev, logic [31:0] exp);
        addr  = AW'(a);
        sel_n = 4'h0;
        wr_n  = 4'hF;
        oe_n  = 1'b0;
        tick();
        for (int i = 0; i < LEN - 1; i++) tick();
        if (chk_prev) check("R6 previous byte before sense completes", rdata, prev);
        tick();
        check("R6 sensed word", rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle();
        addr  = '0;
        wdata = '0;
        @(negedge clk);
        tick();
        tick();
        check("R1 restart flag in reset", {28'd0, sense_restart}, 32'd0);
        check("R1 drive enable in reset", {28'd0, drive_en}, 32'd0);
        // R1: first driven cycle after reset shows the cleared register.
        rst_n = 1'b1;
        sel_n = 4'h0;
        oe_n  = 1'b0;
        tick();
        check("R1 cleared sensed bytes", rdata, 32'd0);
        check("R5 drive enable on read", {28'd0, drive_en}, 32'hF);
        idle();
        tick();

        // R2/R4: fill every address of every bank.
        for (int a = 0; a < NA; a++) begin
            addr  = AW'(a);
            sel_n = 4'h0;
            wr_n  = 4'h0;
            oe_n  = 1'b0;
            wdata = word(a);
            tick();
            check("R4 lanes undriven during write", {28'd0, drive_en} | rdata, 32'd0);
        end
        idle();
        tick();

        // R2/R6: full read sweep with latency boundary.
        for (int a = 0; a < NA; a++)
            read_at(a, (a > 0) ? word(a - 1) : 32'd0, a > 0, word(a));

        // R3: banks 1 and 3 in standby, no trigger for banks 0 and 2.
        sel_n = 4'b1010;
        tick();
        check("R3 standby lanes read zero", rdata, word(NA - 1) & 32'h00FF_00FF);
        check("R3 standby drive enable", {28'd0, drive_en}, 32'h5);

        // R3/R2: only bank 2 selected; strobes and data on others ignored.
        addr  = AW'(5);
        sel_n = 4'b1011;
        wr_n  = 4'b0000;
        wdata = 32'hA1B2_C3D4;
        tick();
        idle();
        tick();
        read_at(5, 32'd0, 1'b0, {pat(3, 5), 8'hB2, pat(1, 5), pat(0, 5)});

        // R2: write with output enable high still stores.
        addr  = AW'(6);
        sel_n = 4'h0;
        wr_n  = 4'h0;
        oe_n  = 1'b1;
        wdata = 32'h0BAD_F00D;
        tick();
        idle();
        tick();
        read_at(6, 32'd0, 1'b0, 32'h0BAD_F00D);

        // R5: output enable alone hides and reveals without a sense.
        oe_n = 1'b1;
        tick();
        check("R5 output disabled lanes", rdata, 32'd0);
        check("R5 output disabled drive", {28'd0, drive_en}, 32'd0);
        oe_n = 1'b0;
        tick();
        check("R5 output re-enabled shows held word", rdata, 32'h0BAD_F00D);

        // R7: rewrite the held address without a trigger.
        wr_n  = 4'h0;
        wdata = 32'h1234_5678;
        tick();
        wr_n = 4'hF;
        tick();
        check("R7 stale word after rewrite", rdata, 32'h0BAD_F00D);
        for (int i = 0; i < LEN; i++) tick();
        check("R7 stale word persists", rdata, 32'h0BAD_F00D);
        // Reselect to trigger a fresh sense.
        sel_n = 4'hF;
        tick();
        sel_n = 4'h0;
        tick();
        for (int i = 0; i < LEN - 1; i++) tick();
        check("R6 old word until completion", rdata, 32'h0BAD_F00D);
        tick();
        check("R7 new word after trigger", rdata, 32'h1234_5678);

        // R8: second change inside the window merges.
        addr = AW'(10);
        tick();
        addr = AW'(11);
        tick();
        check("R8 no restart on merge", {28'd0, sense_restart}, 32'd0);
        for (int i = 0; i < LEN - 2; i++) tick();
        check("R8 old word before merged completion", rdata, 32'h1234_5678);
        tick();
        check("R8 merged sense reads newest address", rdata, word(11));
        check("R8 no restart at completion", {28'd0, sense_restart}, 32'd0);

        // R9: change after the window closes restarts.
        addr = AW'(20);
        tick();
        tick();
        addr = AW'(21);
        tick();
        check("R9 restart flag raised", {28'd0, sense_restart}, 32'hF);
        tick();
        check("R9 restart flag one cycle", {28'd0, sense_restart}, 32'd0);
        check("R9 no completion at original time", rdata, word(11));
        for (int i = 0; i < LEN - 2; i++) tick();
        check("R9 old word before restarted completion", rdata, word(11));
        tick();
        check("R9 restarted sense reads new address", rdata, word(21));

        report();
        $finish;
    end

endmodule